// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense

This block is the per-pin sensing core of a 16-pin general purpose port. It takes raw pin levels and a set of configuration words supplied as ports (direction, input enable, polarity, edge select, both-edge select and two interrupt masks). Each pin marked as an input is sampled through a synchronizer into a captured data word. Every cycle the block compares each pin's captured level before and after the update against the trigger mode chosen for that pin. It then drives two interrupt request lines, A and B, each gated by its own mask.

A pin is triggered in one of three ways:

- **Level sensing:** the trigger is active while the captured level is at the active value that the polarity selects.
- **Single-edge sensing:** one transition direction, picked by the polarity bit, is a trigger.
- **Both-edge sensing:** any change of the captured level is a trigger.

The register bus that holds the configuration lives outside this block.

Top module: `gpio_pin_sense`

## Requirements
- R1: While reset is asserted and directly after it, `capData`, `irqA` and `irqB` are all zero.
- R2: Bit i of `capData` follows pin i only while both `dirEn[i]` and `inEn[i]` are 1. Otherwise the bit holds its last captured value.
- R3: A pin whose `dirEn` or `inEn` bit is 0 never causes `irqA` or `irqB`, even when its input changes.
- R4: With `edgeSel[i]`=1 and `bothSel[i]`=1, every change of captured bit i gives exactly one cycle of interrupt request.
- R5: With `edgeSel[i]`=1, `bothSel[i]`=0 and `polSel[i]`=0, only a 0-to-1 change of captured bit i triggers. A 1-to-0 change does not.
- R6: With `edgeSel[i]`=1, `bothSel[i]`=0 and `polSel[i]`=1, only a 1-to-0 change of captured bit i triggers. A 0-to-1 change does not.
- R7: With `edgeSel[i]`=0 (level mode), pin i triggers in every cycle in which its new captured level differs from `polSel[i]`. Polarity 0 is therefore active high and polarity 1 active low.
- R8: A trigger on pin i raises `irqA` if `maskA[i]`=1 and `irqB` if `maskB[i]`=1, either or both. Each output is the OR over all pins.
- R9: A pin change applied between clock edges reaches `capData` and the interrupt outputs on the third rising edge after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 16 | Raw pin levels |
| dirEn | input | 16 | Per-pin input direction |
| inEn | input | 16 | Per-pin input buffer enable |
| polSel | input | 16 | Per-pin polarity |
| edgeSel | input | 16 | 1 = edge sensing, 0 = level sensing |
| bothSel | input | 16 | In edge sensing, 1 = both edges |
| maskA | input | 16 | Pins routed to request A |
| maskB | input | 16 | Pins routed to request B |
| capData | output | 16 | Captured pin levels |
| irqA | output | 1 | Interrupt request A |
| irqB | output | 1 | Interrupt request B |

## Verification
The bench drives pins that have only one of direction or input enable set. A design that ANDed the wrong bits would capture those levels or raise a request. Single-edge pins are driven in both directions under each polarity, which catches a swapped polarity or a single-edge pin acting as both-edge. The bench also holds level-mode pins at their active value for several cycles, expecting a request every cycle and none after release. It probes the edge just before capture and routes one pin to both masks, so an extra or missing synchronizer stage, or crossed mask routing, shows up as a wrong cycle or a wrong output.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

  localparam int DEF_PINS = 16;
  localparam int DEF_SYNC = 2;

  // Per-pin trigger decoding.
  typedef enum logic [2:0] {
    TRIG_HIGH = 3'd0,
    TRIG_LOW  = 3'd1,
    TRIG_RISE = 3'd2,
    TRIG_FALL = 3'd3,
    TRIG_ANY  = 3'd4
  } trigMode_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic fireA;
    logic fireB;
  } senseStrobe_t;

  function automatic trigMode_t decodeMode(input logic edgeBit, input logic bothBit,
                                           input logic polBit);
    if (edgeBit) begin
      if (bothBit) return TRIG_ANY;
      return polBit ? TRIG_FALL : TRIG_RISE;
    end
    return polBit ? TRIG_LOW : TRIG_HIGH;
  endfunction

endpackage

// File: rtl/gpio_sense_dp.sv
module gpio_sense_dp
  import gpio_sense_pkg::*;
#(
  parameter int PIN_W = DEF_PINS,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIN_W-1:0] pinIn,
  input  logic [PIN_W-1:0] capEn,
  input  senseStrobe_t     strobe,
  output logic [PIN_W-1:0] capData,
  output logic [PIN_W-1:0] nextLvl,
  output logic             irqA,
  output logic             irqB
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][PIN_W-1:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign nextLvl = (capData & ~capEn) | (syncQ[LAST] & capEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capData <= '0;
      irqA    <= 1'b0;
      irqB    <= 1'b0;
    end else begin
      capData <= nextLvl;
      irqA    <= strobe.fireA;
      irqB    <= strobe.fireB;
    end
  end

endmodule

// File: rtl/gpio_sense_ctrl.sv
module gpio_sense_ctrl
  import gpio_sense_pkg::*;
#(
  parameter int PIN_W = DEF_PINS
) (
  input  logic [PIN_W-1:0] dirEn,
  input  logic [PIN_W-1:0] inEn,
  input  logic [PIN_W-1:0] polSel,
  input  logic [PIN_W-1:0] edgeSel,
  input  logic [PIN_W-1:0] bothSel,
  input  logic [PIN_W-1:0] maskA,
  input  logic [PIN_W-1:0] maskB,
  input  logic [PIN_W-1:0] oldLvl,
  input  logic [PIN_W-1:0] newLvl,
  output logic [PIN_W-1:0] capEn,
  output senseStrobe_t     strobe
);

  logic [PIN_W-1:0] pinHit;

  assign capEn = dirEn & inEn;

  for (genvar i = 0; i < PIN_W; i++) begin : gPin
    trigMode_t mode;
    logic      modeHit;
    assign mode = decodeMode(edgeSel[i], bothSel[i], polSel[i]);
    always_comb begin
      unique case (mode)
        TRIG_HIGH: modeHit = newLvl[i];
        TRIG_LOW:  modeHit = !newLvl[i];
        TRIG_RISE: modeHit = !oldLvl[i] && newLvl[i];
        TRIG_FALL: modeHit = oldLvl[i] && !newLvl[i];
        TRIG_ANY:  modeHit = oldLvl[i] ^ newLvl[i];
        default:   modeHit = 1'b0;
      endcase
    end
    assign pinHit[i] = capEn[i] & modeHit;
  end

  assign strobe.fireA = |(pinHit & maskA);
  assign strobe.fireB = |(pinHit & maskB);

endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
  import gpio_sense_pkg::*;
#(
  parameter int PIN_W = DEF_PINS,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIN_W-1:0] pinIn,
  input  logic [PIN_W-1:0] dirEn,
  input  logic [PIN_W-1:0] inEn,
  input  logic [PIN_W-1:0] polSel,
  input  logic [PIN_W-1:0] edgeSel,
  input  logic [PIN_W-1:0] bothSel,
  input  logic [PIN_W-1:0] maskA,
  input  logic [PIN_W-1:0] maskB,
  output logic [PIN_W-1:0] capData,
  output logic             irqA,
  output logic             irqB
);

  logic [PIN_W-1:0] capEn;
  logic [PIN_W-1:0] nextLvl;
  senseStrobe_t     strobe;

  gpio_sense_ctrl #(.PIN_W(PIN_W)) uCtrl (
    .dirEn(dirEn), .inEn(inEn), .polSel(polSel), .edgeSel(edgeSel),
    .bothSel(bothSel), .maskA(maskA), .maskB(maskB),
    .oldLvl(capData), .newLvl(nextLvl), .capEn(capEn), .strobe(strobe)
  );

  gpio_sense_dp #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .capEn(capEn), .strobe(strobe),
    .capData(capData), .nextLvl(nextLvl), .irqA(irqA), .irqB(irqB)
  );

endmodule

// File: rtl/gpio_pin_sense_chk.sv
module gpio_pin_sense_chk #(
  parameter int PIN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [PIN_W-1:0] dirEn,
  input logic [PIN_W-1:0] inEn,
  input logic [PIN_W-1:0] edgeSel,
  input logic [PIN_W-1:0] maskA,
  input logic [PIN_W-1:0] maskB,
  input logic [PIN_W-1:0] capData,
  input logic             irqA,
  input logic             irqB
);

  // R2
  hold_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((capData ^ $past(capData)) & ~$past(dirEn & inEn)) == '0);

  // R3
  irqa_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqA |-> ($past(dirEn & inEn & maskA) != '0));

  // R8
  irqb_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqB |-> ($past(dirEn & inEn & maskB) != '0));

  // R4
  edge_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqA && $past(irqA) && $stable(capData)) |->
      ($past(dirEn & inEn & maskA & ~edgeSel) != '0));

endmodule

bind gpio_pin_sense gpio_pin_sense_chk #(.PIN_W(PIN_W)) uChk (
  .clk(clk), .rstN(rstN), .dirEn(dirEn), .inEn(inEn), .edgeSel(edgeSel),
  .maskA(maskA), .maskB(maskB), .capData(capData), .irqA(irqA), .irqB(irqB)
);

// File: tb/tb_gpio_pin_sense.sv
`timescale 1ns/1ps
module tb_gpio_pin_sense;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pinIn = '0, dirEn = '0, inEn = '0, polSel = '0, edgeSel = '0;
  logic [15:0] bothSel = '0, maskA = '0, maskB = '0;
  logic [15:0] capData;
  logic        irqA, irqB;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  gpio_pin_sense dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .dirEn(dirEn), .inEn(inEn),
    .polSel(polSel), .edgeSel(edgeSel), .bothSel(bothSel), .maskA(maskA),
    .maskB(maskB), .capData(capData), .irqA(irqA), .irqB(irqB)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Advance n rising edges, sample 5 ns after the last.
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  // Put one pin into a known low captured state with all requests quiet.
  task automatic prime(input int b);
    dirEn = '0; inEn = '0; maskA = '0; maskB = '0;
    edgeSel = '0; bothSel = '0; polSel = '0; pinIn = '0;
    dirEn[b] = 1'b1; inEn[b] = 1'b1; edgeSel[b] = 1'b1; bothSel[b] = 1'b1;
    step(5);
  endtask

  task automatic tReset;
    step(2);
    chk("R1 capData in reset", capData, 16'h0);
    chk("R1 irq in reset", {14'h0, irqA, irqB}, 16'h0);
    rstN = 1'b1;
    step(1);
    chk("R1 after release", {capData[13:0], irqA, irqB}, 16'h0);
  endtask

  task automatic tGate;
    prime(3);
    maskA = 16'hFFFF; maskB = 16'hFFFF;
    inEn[3] = 1'b0; pinIn[3] = 1'b1;
    step(4);
    chk("R2 dir only holds", {15'h0, capData[3]}, 16'h0);
    chk("R3 dir only quiet", {14'h0, irqA, irqB}, 16'h0);
    dirEn[3] = 1'b0; inEn[3] = 1'b1; pinIn[3] = 1'b0;
    step(2); pinIn[3] = 1'b1;
    step(4);
    chk("R2 inen only holds", {15'h0, capData[3]}, 16'h0);
    chk("R3 inen only quiet", {14'h0, irqA, irqB}, 16'h0);
    dirEn[3] = 1'b1;
    step(2);
    chk("R2 enabled captures", {15'h0, capData[3]}, 16'h1);
    maskA = '0; maskB = '0; dirEn[3] = 1'b0; pinIn[3] = 1'b0;
    step(4);
    chk("R2 disable keeps last", {15'h0, capData[3]}, 16'h1);
  endtask

  task automatic tBoth;
    prime(5);
    maskA[5] = 1'b1;
    pinIn[5] = 1'b1;
    step(2);
    chk("R9 not yet captured", {15'h0, capData[5]}, 16'h0);
    chk("R9 no early irq", {15'h0, irqA}, 16'h0);
    step(1);
    chk("R9 captured on third edge", {15'h0, capData[5]}, 16'h1);
    chk("R4 rise pulse", {15'h0, irqA}, 16'h1);
    step(1);
    chk("R4 pulse one cycle", {15'h0, irqA}, 16'h0);
    pinIn[5] = 1'b0;
    step(3);
    chk("R4 fall pulse", {15'h0, irqA}, 16'h1);
    step(1);
    chk("R4 fall pulse ends", {15'h0, irqA}, 16'h0);
  endtask

  task automatic tSingle(input logic pol);
    int hits;
    prime(7);
    bothSel[7] = 1'b0; polSel[7] = pol; maskB[7] = 1'b1;
    step(2);
    pinIn[7] = 1'b1;
    step(3);
    chk(pol ? "R6 rise ignored" : "R5 rise fires", {15'h0, irqB}, {15'h0, !pol});
    hits = 0;
    pinIn[7] = 1'b0;
    for (int k = 0; k < 5; k++) begin step(1); hits += int'(irqB); end
    chk(pol ? "R6 fall fires once" : "R5 fall ignored", 16'(hits), {15'h0, pol});
  endtask

  task automatic tLevel;
    int hits;
    prime(9);
    edgeSel[9] = 1'b0; bothSel[9] = 1'b0; maskA[9] = 1'b1;
    step(2);
    pinIn[9] = 1'b1;
    step(3);
    hits = 0;
    for (int k = 0; k < 4; k++) begin hits += int'(irqA); step(1); end
    chk("R7 active high repeats", 16'(hits), 16'd4);
    pinIn[9] = 1'b0;
    step(4);
    chk("R7 released", {15'h0, irqA}, 16'h0);
    polSel[9] = 1'b1;
    step(1);
    hits = 0;
    for (int k = 0; k < 3; k++) begin hits += int'(irqA); step(1); end
    chk("R7 active low repeats", 16'(hits), 16'd3);
  endtask

  task automatic tMask;
    prime(2);
    maskB[2] = 1'b1;
    pinIn[2] = 1'b1;
    step(3);
    chk("R8 only B", {14'h0, irqA, irqB}, 16'h1);
    maskA[2] = 1'b1;
    pinIn[2] = 1'b0;
    step(3);
    chk("R8 both outputs", {14'h0, irqA, irqB}, 16'h3);
    dirEn[14] = 1'b1; inEn[14] = 1'b1; edgeSel[14] = 1'b1; bothSel[14] = 1'b1;
    maskA = 16'h4000; maskB = '0;
    step(4);
    pinIn[14] = 1'b1; pinIn[2] = 1'b1;
    step(3);
    chk("R8 OR over pins", {14'h0, irqA, irqB}, 16'h2);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tGate();
    tBoth();
    tSingle(1'b0);
    tSingle(1'b1);
    tLevel();
    tMask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule